// File: doc/BRIEF.md
# Source-Synchronous Dual-Clock Link

This block carries words from a source clock domain to an unrelated destination clock domain. The transmit end forwards its own clock to the receiving storage together with each word, but lets that forwarded clock pulse only for edges that carry a valid word. Between acceptance and the forwarded edge, each word passes through a selectable number of register taps. The taps model a data-path delay that keeps the forwarded rising edge inside the data's stable window. The receive end is a circular buffer. It is written on the forwarded clock and read on the destination clock.

The flow-control flags are formed only from Gray-coded pointers that cross through two-flop synchronizers. The source sees a full flag and stops presenting words while it is high. The destination pops a word with a read request and sees an empty flag. The delay setting is chosen while the link is idle and held steady while words are in flight.

Top module: `ss_link`

## Requirements
- R1: After reset the empty flag is 1, the full flag is 0 and the forwarded link clock stays low while no word is offered.
- R2: Every accepted word is delivered on `rd_data` exactly once, in acceptance order, for any mix of write and read patterns.
- R3: The forwarded link clock gives exactly one rising edge per accepted word and none while the source is idle.
- R4: With `delay_sel` = d (0 to 7), a word accepted on source edge k is written on source edge k+d. The empty flag therefore stays 1 at least until just after edge k+d and falls within six further source cycles.
- R5: The full flag is 1 whenever DEPTH words (8 by default) are accepted but not yet read. A word offered while full is high is not accepted and never appears at the read side.
- R6: The empty flag is 1 whenever no unread word exists. A read request while empty is high is ignored and leaves the read position unchanged.
- R7: Only Gray-coded pointers one bit wider than the address cross between domains, each through two flops. The synchronized read pointer seen by the source changes by at most one bit per source cycle.
- R8: Once reads free space, the full flag returns to 0 after the read pointer has crossed back to the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock, free-running |
| src_rst_n | input | 1 | Source-domain synchronous reset, active low |
| src_valid | input | 1 | Source offers `src_data` this cycle |
| src_data | input | DATA_W | Word offered by the source |
| delay_sel | input | SEL_W | Number of data-path delay taps (0 to 7), held while the link is active |
| src_full | output | 1 | No room for another word; the source must hold off |
| link_clk | output | 1 | Forwarded, gated write clock |
| dst_clk | input | 1 | Destination clock |
| dst_rst_n | input | 1 | Destination-domain synchronous reset, active low |
| rd_req | input | 1 | Pop the word shown on `rd_data` |
| rd_data | output | DATA_W | Oldest unread word (valid when `empty` is 0) |
| empty | output | 1 | No unread word is present |

## Verification
The bench runs the link with the source clock at 14 ns and the destination clock at 20 ns. It uses several traffic mixes: a back-to-back burst against a reader that pops every cycle, and sparse writes with gaps against a reader that pops every other cycle. These two mixes separate pointer-advance errors from crossing errors. A source that keeps `valid` high into a stalled reader shows whether words are dropped or duplicated at the full boundary. Read requests held against an empty buffer, followed by a single word, show whether an ignored pop still moved the read position. A sweep of all eight delay settings, one word at a time, measures when empty falls, which exposes a wrong tap count. Counting forwarded clock edges against accepted words exposes a gate that leaks pulses or swallows them.

// File: rtl/ssl_pkg.sv
// Shared defaults for the source-synchronous link.
// Assumes: address width >= 1, so depth is a power of two of at least 2.
package ssl_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_ADDR_W = 3;
    localparam int DEF_SEL_W  = 3;
endpackage

// File: rtl/ssl_sync.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes: the input changes by at most one bit between destination edges
// (or stays a valid code when it moves further), and reset is synchronous and active low.
module ssl_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages resolve the asynchronous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ssl_tx.sv
// Transmit end: delays each accepted word by delay_sel source cycles and
// forwards a gated copy of the source clock that pulses once per delayed word.
// Assumes: delay_sel changes only while no word is in the taps; the gate
// enable is captured on the falling edge so the gated clock cannot glitch.
module ssl_tx #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEL_W-1:0]  delay_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              link_clk
);
    localparam int MAXD = (1 << SEL_W) - 1;

    logic              tap_v [1:MAXD];
    logic [DATA_W-1:0] tap_d [1:MAXD];
    logic              dly_v;
    logic              gate_en;

    // Shift accepted words through the delay taps.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            for (int i = 1; i <= MAXD; i++) begin
                tap_v[i] <= 1'b0;
                tap_d[i] <= '0;
            end
        end else begin
            tap_v[1] <= accept;
            tap_d[1] <= in_data;
            for (int i = 2; i <= MAXD; i++) begin
                tap_v[i] <= tap_v[i-1];
                tap_d[i] <= tap_d[i-1];
            end
        end
    end

    // Pick the tap given by delay_sel; zero bypasses the taps.
    always_comb begin
        if (delay_sel == '0) begin
            dly_v    = accept;
            out_data = in_data;
        end else begin
            dly_v    = tap_v[delay_sel];
            out_data = tap_d[delay_sel];
        end
    end

    // Capture the gate on the falling edge; the clock runs freely during reset.
    always_ff @(negedge src_clk) begin
        if (!src_rst_n) begin
            out_valid <= 1'b0;
            gate_en   <= 1'b1;
        end else begin
            out_valid <= dly_v;
            gate_en   <= dly_v;
        end
    end

    assign link_clk = src_clk & gate_en;

    // R4: with no taps, a word accepted this cycle is marked for this edge.
    a_r4_zero_tap_marks: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (accept && delay_sel == '0) |-> out_valid);
endmodule

// File: rtl/ssl_fifo.sv
// Receive end: circular storage written on the forwarded clock and read on
// the destination clock. Full is a credit count in the source domain
// against the synchronized read pointer; empty compares the read pointer
// with the synchronized write pointer.
// Assumes: wr_en is high only for edges that carry a word, and at most
// DEPTH words are accepted ahead of the reader.
module ssl_fifo #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              accept,
    output logic              full,
    input  logic              fwd_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, wgray_s;
    logic [PW-1:0] rbin, rgray, rgray_s, rbin_s;
    logic [PW-1:0] credit, rbin_next;
    logic          pop;

    // Store the forwarded word; storage needs no reset.
    always_ff @(posedge fwd_clk) begin
        if (wr_en && src_rst_n) mem[wbin[ADDR_W-1:0]] <= wr_data;
    end

    // Advance the write pointer and its Gray copy on each forwarded word.
    always_ff @(posedge fwd_clk) begin
        if (!src_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin + 1'b1;
            wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
        end
    end

    // Count accepted words in the source domain for the full flag.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) credit <= '0;
        else if (accept) credit <= credit + 1'b1;
    end

    ssl_sync #(.W(PW)) u_rd_to_src (
        .clk(src_clk), .rst_n(src_rst_n), .d(rgray), .q(rgray_s));

    ssl_sync #(.W(PW)) u_wr_to_dst (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(wgray), .q(wgray_s));

    // Convert the synchronized Gray read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign full = ((credit - rbin_s) == PW'(DEPTH));

    assign empty     = (rgray == wgray_s);
    assign pop       = rd_req && !empty;
    assign rbin_next = rbin + 1'b1;
    assign rd_data   = mem[rbin[ADDR_W-1:0]];

    // Advance the read pointer and its Gray copy on each accepted pop.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_next;
            rgray <= rbin_next ^ (rbin_next >> 1);
        end
    end

    // R5: the source never runs more than DEPTH words ahead of the reader.
    a_r5_no_overflow: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (credit - rbin_s) <= PW'(DEPTH));

    // R6: a request against an empty buffer leaves the read pointer alone.
    a_r6_empty_pop_ignored: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (empty && rd_req) |=> $stable(rbin));

    // R7: the read pointer seen by the source moves one Gray step at a time.
    a_r7_gray_single_step: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(rgray_s ^ $past(rgray_s)) <= 1);
endmodule

// File: rtl/ss_link.sv
// Top of the source-synchronous link: accepts words while not full, sends
// them through the delay taps and gated forwarded clock, and buffers them
// for the destination reader.
// Assumes: the source holds delay_sel steady while words are in flight.
module ss_link
    import ssl_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [SEL_W-1:0]  delay_sel,
    output logic              src_full,
    output logic              link_clk,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    logic              accept;
    logic              fwd_valid;
    logic [DATA_W-1:0] fwd_data;

    assign accept = src_valid && !src_full;

    ssl_tx #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_tx (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .accept(accept),
        .in_data(src_data), .delay_sel(delay_sel), .out_valid(fwd_valid),
        .out_data(fwd_data), .link_clk(link_clk));

    ssl_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .accept(accept),
        .full(src_full), .fwd_clk(link_clk), .wr_en(fwd_valid),
        .wr_data(fwd_data), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .rd_req(rd_req), .rd_data(rd_data), .empty(empty));
endmodule

// File: tb/ss_link_bench.sv
`timescale 1ns/1ps
module ss_link_bench;
    localparam int DEPTH = 8;

    logic        src_clk = 0, dst_clk = 0;
    logic        src_rst_n = 0, dst_rst_n = 0;
    logic        src_valid = 0;
    logic [15:0] src_data = '0;
    logic [2:0]  delay_sel = '0;
    logic        src_full, link_clk, rd_req = 0, empty;
    logic [15:0] rd_data;

    int  checks = 0, errors = 0;
    int  q[$];
    int  next_word = 100, n_acc = 0, n_pop = 0, link_edges = 0;
    bit  count_on = 0, rd_on = 0, rd_alt = 0, rd_tgl = 0, done = 0;

    ss_link u_ss_link (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_data(src_data), .delay_sel(delay_sel), .src_full(src_full),
        .link_clk(link_clk), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .rd_req(rd_req), .rd_data(rd_data), .empty(empty));

    always #7  src_clk = ~src_clk;
    always #10 dst_clk = ~dst_clk;

    always @(posedge link_clk) if (count_on) link_edges++;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One source cycle at posedge+2: check full, offer a word, step an edge.
    task automatic src_step(bit v);
        if (q.size() == DEPTH) chk(src_full == 1'b1, "R5", "full at depth", int'(src_full), 1);
        src_valid = v;
        src_data  = 16'(next_word);
        if (v && !src_full) begin
            q.push_back(next_word);
            next_word++;
            n_acc++;
        end
        @(posedge src_clk); #2;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) src_step(1'b0);
    endtask

    // Reference reader: pops and compares on every destination cycle.
    initial begin
        wait (dst_rst_n);
        forever begin
            @(posedge dst_clk); #2;
            if (q.size() == 0) chk(empty == 1'b1, "R6", "empty with nothing unread", int'(empty), 1);
            rd_tgl = ~rd_tgl;
            rd_req = rd_on && (!rd_alt || rd_tgl);
            if (rd_req && !empty) begin
                if (q.size() == 0) chk(1'b0, "R2", "pop with no word in model", 0, 1);
                else begin
                    chk(int'(rd_data) == q[0], "R2 R7", "read word", int'(rd_data), q[0]);
                    void'(q.pop_front());
                    n_pop++;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge src_clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (5) @(posedge dst_clk);
        #2 dst_rst_n = 1;
        @(posedge src_clk); #2 src_rst_n = 1;
        @(posedge src_clk); #2;
        @(posedge src_clk); #2;
        // R1: reset state and a quiet link clock.
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        chk(src_full == 1'b0, "R1", "full after reset", int'(src_full), 0);
        count_on = 1;
        idle(10);
        chk(link_edges == 0, "R1", "link clock quiet when idle", link_edges, 0);

        // R2: back-to-back burst, reader pops every cycle, no delay taps.
        rd_on = 1; rd_alt = 0; delay_sel = 3'd0;
        for (int i = 0; i < 20; i++) src_step(1'b1);
        idle(30);
        chk(q.size() == 0, "R2", "burst drained", q.size(), 0);

        // R2: sparse writes through three taps, reader every other cycle.
        rd_alt = 1; delay_sel = 3'd3;
        for (int i = 0; i < 15; i++) begin
            src_step(1'b1);
            idle(2);
        end
        idle(40);
        chk(q.size() == 0, "R2", "sparse drained", q.size(), 0);
        chk(link_edges == n_acc, "R3", "one link edge per word", link_edges, n_acc);

        // R5: stalled reader, source keeps valid high past full.
        rd_on = 0; rd_alt = 0; delay_sel = 3'd1;
        for (int i = 0; i < 12; i++) src_step(1'b1);
        chk(src_full == 1'b1, "R5", "full with stalled reader", int'(src_full), 1);
        chk(q.size() == DEPTH, "R5", "words accepted before stall", q.size(), DEPTH);
        for (int i = 0; i < 5; i++) src_step(1'b1);
        chk(link_edges == n_acc, "R3", "no link edge while full", link_edges, n_acc);
        src_valid = 0;
        rd_on = 1;
        idle(40);
        chk(src_full == 1'b0, "R8", "full released after reads", int'(src_full), 0);
        chk(empty == 1'b1, "R6", "empty after drain", int'(empty), 1);
        chk(q.size() == 0, "R5", "only accepted words read", q.size(), 0);

        // R6: read requests against an empty buffer, then one word.
        seen = n_pop;
        idle(10);
        chk(n_pop == seen, "R6", "no pop while empty", n_pop - seen, 0);
        delay_sel = 3'd0;
        src_step(1'b1);
        idle(15);
        chk(n_pop == seen + 1, "R6", "single word after empty reads", n_pop - seen, 1);

        // R4: sweep every delay setting with a lone word.
        for (int d = 0; d < 8; d++) begin
            int waited;
            rd_on = 0;
            delay_sel = 3'(d);
            src_step(1'b1);
            src_valid = 0;
            for (int i = 0; i < d; i++) src_step(1'b0);
            chk(empty == 1'b1, "R4", $sformatf("empty held through tap %0d", d), int'(empty), 1);
            waited = 0;
            for (int i = 0; i < 6 && empty; i++) begin
                src_step(1'b0);
                waited++;
            end
            chk(empty == 1'b0, "R4", $sformatf("word visible for tap %0d", d), int'(empty), 0);
            rd_on = 1;
            idle(10);
        end
        chk(q.size() == 0, "R2", "sweep drained", q.size(), 0);

        idle(10);
        chk(link_edges == n_acc, "R3", "total link edges", link_edges, n_acc);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule